// File: doc/BRIEF.md
# Packed Ternary Weight Decoder

This block turns a stream of packed weight bytes into a stream of single ternary weights. Each weight leaves as a 2-bit code and goes to a dot-product engine that adds, subtracts or skips an activation. The block reads two packings, chosen per byte by a mode input. The radix-3 packing holds five weights in one byte, which costs 1.6 bits per weight. The pair packing holds four 2-bit fields per byte and is simpler to decode.

A weight count, sampled when the first byte of a tensor is accepted, sets the tensor length. Weights past that count in the final byte are padding and are dropped. The final weight kept carries a last marker. Bytes arrive on a valid/ready handshake and weights leave on another one. The block sustains one weight per cycle because it accepts the next byte in the same cycle that the current byte gives up its final weight.

Top module: `tern_unpack`

## Requirements
- R1: Output codes are 01 for +1, 11 for -1 and 00 for 0. In radix-3 mode (dense_mode=1) a byte v = d0 + 3*d1 + 9*d2 + 27*d3 + 81*d4 is emitted d0 first and d4 last, with digit 0 meaning -1, digit 1 meaning 0 and digit 2 meaning +1.
- R2: In pair mode (dense_mode=0) bits [1:0] are emitted first, then [3:2], [5:4] and [7:6]. A field of 01 is +1, 11 is -1, 00 is 0, and the unused field 10 is emitted as 0.
- R3: A radix-3 byte of value 243 to 255 is emitted as five 0 weights and sets code_error. code_error stays set until reset, across later tensors.
- R4: weight_count is sampled when the first byte of a tensor is accepted and must be at least 1. Exactly that many weights are emitted. Weights past it in the final byte are discarded, and trit_last is high only on the final weight.
- R5: While trit_valid is high and trit_ready is low, trit_valid, trit_code and trit_last hold their values.
- R6: With bytes always offered and trit_ready held high, there is no idle cycle between the first and last weight of a tensor. in_ready is high in the cycle the last weight of a byte is taken.
- R7: After reset, trit_valid and code_error are 0 and in_ready is 1.
- R8: dense_mode is sampled with each accepted byte, so one tensor may mix the two packings byte by byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dense_mode | input | 1 | 1: radix-3 byte, 0: pair-packed byte; sampled per byte |
| weight_count | input | CNT_W | Weights in the tensor, sampled at its first byte |
| in_valid | input | 1 | Packed byte offered |
| in_byte | input | 8 | Packed byte |
| in_ready | output | 1 | Byte accepted when high with in_valid |
| trit_valid | output | 1 | A weight is presented |
| trit_ready | input | 1 | Consumer takes the weight |
| trit_code | output | 2 | Weight code: 01 +1, 11 -1, 00 0 |
| trit_last | output | 1 | Final weight of the tensor |
| code_error | output | 1 | Sticky flag for an out-of-range radix-3 byte |

## Verification
The hardest case to reach from the ports is a tensor end that falls inside a byte while that same cycle could also refill the byte holder. The discard, the reload of the count and the in_ready path all meet in that cycle. The stimulus sets counts that are not multiples of five or four, and it runs tensors back to back with no reset between them. It also mixes packings inside one tensor. Stalls come from a periodic trit_ready pattern that lands on byte edges, so R5 is checked at those edges as well.

// File: rtl/tern_pkg.sv
package tern_pkg;
  localparam int BYTE_W      = 8;
  localparam int DENSE_SLOTS = 5;
  localparam int PAIR_SLOTS  = BYTE_W / 2;
  localparam int SLOT_W      = $clog2(DENSE_SLOTS + 1);
  localparam int DENSE_LIMIT = 3 ** DENSE_SLOTS;

  typedef enum logic [1:0] {
    TC_ZERO = 2'b00,
    TC_POS  = 2'b01,
    TC_NEG  = 2'b11
  } tcode_e;

  // Bit-serial restoring division by three: returns {remainder, quotient}.
  function automatic logic [BYTE_W+1:0] div3(input logic [BYTE_W-1:0] v);
    logic [2:0]        acc;
    logic [BYTE_W-1:0] q;
    acc = 3'd0;
    q   = '0;
    for (int i = BYTE_W - 1; i >= 0; i--) begin
      acc = {acc[1:0], v[i]};
      if (acc >= 3'd3) begin
        acc  = acc - 3'd3;
        q[i] = 1'b1;
      end
    end
    return {acc[1:0], q};
  endfunction

  function automatic tcode_e digit_code(input logic [1:0] d);
    case (d)
      2'd0:    return TC_NEG;
      2'd2:    return TC_POS;
      default: return TC_ZERO;
    endcase
  endfunction

  function automatic tcode_e pair_code(input logic [1:0] p);
    case (p)
      2'b01:   return TC_POS;
      2'b11:   return TC_NEG;
      default: return TC_ZERO;
    endcase
  endfunction
endpackage

// File: rtl/tern_digit.sv
module tern_digit
  import tern_pkg::*;
(
  input  logic [BYTE_W-1:0] work,
  input  logic              dense,
  input  logic              bad,
  output logic [1:0]        code,
  output logic [BYTE_W-1:0] work_next
);
  logic [BYTE_W+1:0] qr;

  always_comb begin
    qr = div3(work);
    if (dense) begin
      code      = bad ? TC_ZERO : digit_code(qr[BYTE_W+1:BYTE_W]);
      work_next = qr[BYTE_W-1:0];
    end else begin
      code      = pair_code(work[1:0]);
      work_next = work >> 2;
    end
  end
endmodule

// File: rtl/tern_cnt.sv
module tern_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             fire,
  input  logic             take,
  input  logic [CNT_W-1:0] count_in,
  output logic             is_last
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] rem_q, rem_d, rem_dec;

  always_comb begin
    rem_dec = fire ? (rem_q - ONE) : rem_q;
    rem_d   = rem_dec;
    if (take && (rem_dec == '0)) rem_d = count_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                rem_q <= '0;
    else if (fire || take)     rem_q <= rem_d;
  end

  assign is_last = (rem_q == ONE);

  // R4: a byte is never held without weights left to emit
  p_rem_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (rem_q != '0));
  // R4: the final weight ends the tensor
  p_last_ends_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && is_last && !take) |=> (rem_q == '0));
endmodule

// File: rtl/tern_unpack.sv
module tern_unpack
  import tern_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dense_mode,
  input  logic [CNT_W-1:0] weight_count,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  output logic             in_ready,
  output logic             trit_valid,
  input  logic             trit_ready,
  output logic [1:0]       trit_code,
  output logic             trit_last,
  output logic             code_error
);
  localparam logic [SLOT_W-1:0] N_DENSE = SLOT_W'(DENSE_SLOTS);
  localparam logic [SLOT_W-1:0] N_PAIR  = SLOT_W'(PAIR_SLOTS);
  localparam logic [SLOT_W-1:0] S_ONE   = SLOT_W'(1);

  logic              busy_q, busy_d;
  logic [BYTE_W-1:0] work_q, work_d, work_nx;
  logic [SLOT_W-1:0] left_q, left_d;
  logic              dense_q, dense_d;
  logic              bad_q, bad_d;
  logic              err_q, err_d;
  logic              fire, byte_done, take, is_last, bad_in;
  logic [1:0]        code_w;

  tern_digit u_digit (
    .work      (work_q),
    .dense     (dense_q),
    .bad       (bad_q),
    .code      (code_w),
    .work_next (work_nx)
  );

  tern_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (busy_q),
    .fire     (fire),
    .take     (take),
    .count_in (weight_count),
    .is_last  (is_last)
  );

  assign fire      = busy_q & trit_ready;
  assign byte_done = fire & ((left_q == S_ONE) | is_last);
  assign in_ready  = ~busy_q | byte_done;
  assign take      = in_valid & in_ready;
  assign bad_in    = dense_mode & (in_byte >= 8'(DENSE_LIMIT));

  always_comb begin
    busy_d  = busy_q;
    work_d  = work_q;
    left_d  = left_q;
    dense_d = dense_q;
    bad_d   = bad_q;
    err_d   = err_q | (take & bad_in);
    if (fire) begin
      work_d = work_nx;
      left_d = left_q - S_ONE;
      if (byte_done) busy_d = 1'b0;
    end
    if (take) begin
      busy_d  = 1'b1;
      work_d  = in_byte;
      left_d  = dense_mode ? N_DENSE : N_PAIR;
      dense_d = dense_mode;
      bad_d   = bad_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      err_q  <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work_q  <= '0;
      left_q  <= '0;
      dense_q <= 1'b0;
      bad_q   <= 1'b0;
    end else if (fire || take) begin
      work_q  <= work_d;
      left_q  <= left_d;
      dense_q <= dense_d;
      bad_q   <= bad_d;
    end
  end

  assign trit_valid = busy_q;
  assign trit_code  = busy_q ? code_w : 2'b00;
  assign trit_last  = busy_q & is_last;
  assign code_error = err_q;

  // R1: only the three legal codes are emitted
  p_code_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    trit_valid |-> (trit_code != 2'b10));
  // R5: a stalled weight holds still
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (trit_valid && !trit_ready) |=> (trit_valid && $stable(trit_code) && $stable(trit_last)));
  // R3: the error flag never clears without reset
  p_err_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    code_error |=> code_error);
  // R3: an out-of-range byte yields only zero weights
  p_bad_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (trit_valid && bad_q) |-> (trit_code == 2'b00));
  // R6: a byte offered at a byte edge keeps the stream busy
  p_refill_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && in_valid) |=> trit_valid);
endmodule

// File: tb/tern_unpack_test.sv
module tern_unpack_test;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             dense_mode;
  logic [CNT_W-1:0] weight_count;
  logic             in_valid;
  logic [7:0]       in_byte;
  logic             in_ready;
  logic             trit_valid;
  logic             trit_ready;
  logic [1:0]       trit_code;
  logic             trit_last;
  logic             code_error;

  int n_vec  = 0;
  int n_fail = 0;

  logic [7:0] bval [16];
  logic       bmode[16];
  logic [1:0] expc [80];

  always #5 clk = ~clk;

  tern_unpack #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .dense_mode(dense_mode), .weight_count(weight_count),
    .in_valid(in_valid), .in_byte(in_byte), .in_ready(in_ready),
    .trit_valid(trit_valid), .trit_ready(trit_ready), .trit_code(trit_code),
    .trit_last(trit_last), .code_error(code_error)
  );

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic apply_reset();
    rst_n = 1'b0; in_valid = 1'b0; in_byte = '0; dense_mode = 1'b0;
    trit_ready = 1'b0; weight_count = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  function automatic logic [1:0] ref_digit(input int d);
    return (d == 0) ? 2'b11 : (d == 2) ? 2'b01 : 2'b00;
  endfunction

  function automatic logic [1:0] ref_pair(input logic [1:0] p);
    return (p == 2'b01) ? 2'b01 : (p == 2'b11) ? 2'b11 : 2'b00;
  endfunction

  // stall: 0 = consumer always ready, 1 = periodic stalls
  task automatic run_tensor(input int nbytes, input int count, input int stall,
                            input bit exp_err, input string tag);
    int n = 0;
    int bi = 0, ti = 0, cyc = 0;
    bit prev_stall = 0, seen = 0, gap = 0;
    logic [1:0] prev_code = '0;
    for (int b = 0; b < nbytes; b++) begin
      int v = bval[b];
      if (bmode[b]) begin
        for (int k = 0; k < 5; k++) begin
          expc[n++] = (v >= 243) ? 2'b00 : ref_digit(v % 3);
          if (v < 243) v = v / 3;
        end
      end else begin
        for (int k = 0; k < 4; k++) expc[n++] = ref_pair(bval[b][2*k +: 2]);
      end
    end
    weight_count = CNT_W'(count);
    while (ti < count && cyc < 3000) begin
      @(negedge clk);
      trit_ready = (stall != 0) ? ((cyc % 3) != 1) : 1'b1;
      if (bi < nbytes) begin
        in_valid = 1'b1; in_byte = bval[bi]; dense_mode = bmode[bi];
      end else in_valid = 1'b0;
      #1;
      if (prev_stall)
        check(trit_valid && trit_code == prev_code, "R5", "stalled code", int'(trit_code), int'(prev_code));
      if (in_valid && in_ready) bi++;
      if (trit_valid && trit_ready) begin
        check(trit_code == expc[ti], tag, $sformatf("weight %0d code", ti), int'(trit_code), int'(expc[ti]));
        check(trit_last == (ti == count - 1), "R4", $sformatf("last flag at %0d", ti), int'(trit_last), int'(ti == count - 1));
        ti++;
        seen = 1;
      end else if (seen && stall == 0) gap = 1;
      prev_stall = trit_valid && !trit_ready;
      prev_code  = trit_code;
      cyc++;
    end
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    check(ti == count, tag, "weights emitted", ti, count);
    check(!trit_valid, "R4", "padding dropped", int'(trit_valid), 0);
    check(bi == nbytes, "R4", "bytes consumed", bi, nbytes);
    check(code_error == exp_err, "R3", "error flag", int'(code_error), int'(exp_err));
    if (stall == 0) check(!gap, "R6", "idle cycle inside tensor", int'(gap), 0);
  endtask

  task automatic t_reset_r7();
    apply_reset();
    #1;
    check(!trit_valid, "R7", "trit_valid after reset", int'(trit_valid), 0);
    check(in_ready, "R7", "in_ready after reset", int'(in_ready), 1);
    check(!code_error, "R7", "code_error after reset", int'(code_error), 0);
  endtask

  task automatic t_dense_r1();
    apply_reset();
    bval[0] = 8'd0;   bval[1] = 8'd242; bval[2] = 8'd121;
    bval[3] = 8'd5;   bval[4] = 8'd200;
    for (int i = 0; i < 5; i++) bmode[i] = 1'b1;
    run_tensor(5, 25, 0, 1'b0, "R1");
  endtask

  task automatic t_pair_r2();
    apply_reset();
    bval[0] = 8'hE4; bval[1] = 8'h1B; bval[2] = 8'hAA;
    for (int i = 0; i < 3; i++) bmode[i] = 1'b0;
    run_tensor(3, 12, 0, 1'b0, "R2");
  endtask

  task automatic t_trunc_r4();
    apply_reset();
    bval[0] = 8'd17; bval[1] = 8'd222; bval[2] = 8'd100;
    for (int i = 0; i < 3; i++) bmode[i] = 1'b1;
    run_tensor(3, 12, 0, 1'b0, "R4");
    bval[0] = 8'h5D; bval[1] = 8'hC7; bval[2] = 8'h3F;
    for (int i = 0; i < 3; i++) bmode[i] = 1'b0;
    run_tensor(3, 9, 0, 1'b0, "R4");
    bval[0] = 8'd80;
    bmode[0] = 1'b1;
    run_tensor(1, 1, 0, 1'b0, "R4");
  endtask

  task automatic t_stall_r5();
    apply_reset();
    bval[0] = 8'd7; bval[1] = 8'h9C; bval[2] = 8'd241; bval[3] = 8'h63;
    bmode[0] = 1'b1; bmode[1] = 1'b0; bmode[2] = 1'b1; bmode[3] = 1'b0;
    run_tensor(4, 17, 1, 1'b0, "R5");
  endtask

  task automatic t_mixed_r8();
    apply_reset();
    bval[0] = 8'd190; bval[1] = 8'h4D; bval[2] = 8'd33; bval[3] = 8'hD1;
    bmode[0] = 1'b1; bmode[1] = 1'b0; bmode[2] = 1'b1; bmode[3] = 1'b0;
    run_tensor(4, 18, 0, 1'b0, "R8");
  endtask

  task automatic t_invalid_r3();
    apply_reset();
    bval[0] = 8'd243; bval[1] = 8'd255; bval[2] = 8'd100;
    for (int i = 0; i < 3; i++) bmode[i] = 1'b1;
    run_tensor(3, 15, 0, 1'b1, "R3");
    bval[0] = 8'd60; bmode[0] = 1'b1;
    run_tensor(1, 5, 0, 1'b1, "R3");
    apply_reset();
    #1;
    check(!code_error, "R3", "error cleared by reset", int'(code_error), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    t_reset_r7();
    t_dense_r1();
    t_pair_r2();
    t_trunc_r4();
    t_stall_r5();
    t_mixed_r8();
    t_invalid_r3();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule